// File: doc/BRIEF.md
# Split-Mode Event Counter Bank

This block holds the event counters of a performance monitor. It has four physical 32-bit counters. A mode bit for each one turns it into two independent 16-bit counters, which gives eight logical counters in total. Software reaches everything through a single-cycle register port: eight logical counter addresses, one control address and one status address. Event pulses arrive on eight increment inputs, one per logical counter.

A software write to a counter never touches the running count. It loads a holding latch and marks that physical counter pending. Each write to the control register that has the enable bit set copies every pending latch into its live counter. This happens both when counting starts and when the register is rewritten during active counting. Overflow of any logical counter sets a sticky status bit. Reading the status register returns the bits and clears them. A mask register, loaded by writing the status address, gates the status bits onto a registered interrupt line.

Top module: `evb_bank`

## Requirements
- R1: After reset every live counter, latch, pending flag, control bit, status bit and mask bit is zero, and `rdata_o` and `irq_o` are 0.
- R2: Control bit 0 is the global enable, and control bit 1+p puts physical counter p into split mode. Logical index i (addresses 0..7) selects physical counter i mod 4. In split mode, indices 0..3 use bits 31:16 and indices 4..7 use bits 15:0, and reads of a half are zero-extended. In unsplit mode, indices 0..3 read and write all 32 bits, while indices 4..7 read 0 and ignore writes.
- R3: A 16-bit logical write replaces only its own half of the physical counter. The other half keeps the value the counter showed before the write.
- R4: A counter write loads the latch and sets the pending flag, and leaves the live counter unaffected. While the flag is set, reads of that counter return the latched value.
- R5: A control write (address 8) with bit 0 set copies every pending latch into its live counter and clears the pending flags. This holds whether or not the enable bit was already set.
- R6: Counters advance only while the enable bit is set. In split mode, `evt_i[p]` increments the upper half and `evt_i[p+4]` increments the lower half, and each half wraps on its own with no carry. In unsplit mode, `evt_i[p]` increments all 32 bits and `evt_i[p+4]` is ignored.
- R7: A logical counter that wraps from all ones to zero sets status bit i, where i is its logical index. The upper half or the full counter sets bit p, and the lower half sets bit p+4.
- R8: A read of the status address (9) returns the status bits and clears them in the same access. An overflow that occurs in that same cycle remains set.
- R9: A write to address 9 loads the 8-bit interrupt mask. `irq_o` is the registered OR of status AND mask, so a zero mask holds it at 0.
- R10: When a commit and an event for the same pending counter fall in one cycle, the committed value is kept and the event is dropped.
- R11: `rdata_o` is registered. It carries the addressed value in the cycle after `rd_en_i`, and holds it until the next read. Address 8 reads back the control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address: 0..7 logical counters, 8 control, 9 status/mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 8 | Event increment pulses, one per logical counter |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The bench first sweeps all eight logical counters in split mode. Each counter gets a distinct number of single-bit event pulses, so a wrong index mapping or a wrong half shows up as a count that does not match. Writes made while counting is active are followed by events on both halves of the same counter. These separate a latched read from a live read, and a commit from a merge taken at the wrong time. Wrap cases from 0xFFFF and 0xFFFFFFFF check that no carry crosses between halves and that the correct status bit is set. Events that arrive in the same cycle as a commit or a status read test the priority rules.

// File: rtl/evb_pkg.sv
package evb_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_FULL = 2'd1,
    WK_HI   = 2'd2,
    WK_LO   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/evb_slice.sv
module evb_slice
  import evb_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          split_i,
  input  logic          cnt_en_i,
  input  logic          evt_hi_i,
  input  logic          evt_lo_i,
  input  wr_kind_e      wr_kind_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          commit_i,
  output logic [CW-1:0] view_o,
  output logic          ovf_hi_o,
  output logic          ovf_lo_o,
  output logic          pending_o
);
  localparam int HW = CW / 2;

  logic [CW-1:0] live_q, latch_q, live_d;
  logic          pend_q;
  logic          load;

  assign load      = commit_i && pend_q;
  assign view_o    = pend_q ? latch_q : live_q;
  assign pending_o = pend_q;

  always_comb begin
    live_d   = live_q;
    ovf_hi_o = 1'b0;
    ovf_lo_o = 1'b0;
    if (load) begin
      live_d = latch_q;
    end else if (cnt_en_i) begin
      if (split_i) begin
        live_d[CW-1:HW] = live_q[CW-1:HW] + {{(HW-1){1'b0}}, evt_hi_i};
        live_d[HW-1:0]  = live_q[HW-1:0]  + {{(HW-1){1'b0}}, evt_lo_i};
        ovf_hi_o = evt_hi_i && (&live_q[CW-1:HW]);
        ovf_lo_o = evt_lo_i && (&live_q[HW-1:0]);
      end else begin
        live_d   = live_q + {{(CW-1){1'b0}}, evt_hi_i};
        ovf_hi_o = evt_hi_i && (&live_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      live_q  <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      live_q <= live_d;
      case (wr_kind_i)
        WK_FULL: latch_q <= wr_data_i;
        WK_HI:   latch_q <= {wr_data_i[HW-1:0], view_o[HW-1:0]};
        WK_LO:   latch_q <= {view_o[CW-1:HW], wr_data_i[HW-1:0]};
        default: latch_q <= latch_q;
      endcase
      if (wr_kind_i != WK_NONE) pend_q <= 1'b1;
      else if (load)            pend_q <= 1'b0;
    end
  end

  a_r4_write_sets_pending: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_kind_i != WK_NONE) |=> pend_q);
  a_r5_commit_clears_pending: assert property (@(posedge clk_i) disable iff (rst_i)
    (commit_i && pend_q && wr_kind_i == WK_NONE) |=> !pend_q);
  a_r10_commit_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    (commit_i && pend_q) |=> (live_q == $past(latch_q)));
  a_r6_hold_when_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cnt_en_i && !commit_i) |=> $stable(live_q));
  a_r3_hi_write_keeps_lo: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_kind_i == WK_HI) |=> (latch_q[HW-1:0] == $past(view_o[HW-1:0])));
  a_r3_lo_write_keeps_hi: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_kind_i == WK_LO) |=> (latch_q[CW-1:HW] == $past(view_o[CW-1:HW])));
endmodule

// File: rtl/evb_status.sv
module evb_status #(
  parameter int NL = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NL-1:0] set_i,
  input  logic          rd_clr_i,
  input  logic          mask_wr_i,
  input  logic [NL-1:0] mask_i,
  output logic [NL-1:0] status_o,
  output logic          irq_o
);
  logic [NL-1:0] status_q, mask_q;
  logic          irq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (rd_clr_i ? '0 : status_q) | set_i;
      if (mask_wr_i) mask_q <= mask_i;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_clr_i && set_i == '0) |=> (status_q == '0));
  a_r8_set_survives_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  a_r9_zero_mask_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (mask_q == '0) |=> !irq_q);
  a_r9_no_status_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_q == '0) |=> !irq_q);
endmodule

// File: rtl/evb_bank.sv
module evb_bank
  import evb_pkg::*;
#(
  parameter int NPHYS = 4,
  parameter int CW    = 32,
  parameter int AW    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CW-1:0]        wdata_i,
  output logic [CW-1:0]        rdata_o,
  input  logic [2*NPHYS-1:0]   evt_i,
  output logic                 irq_o
);
  localparam int NLOG = 2 * NPHYS;
  localparam int HW   = CW / 2;
  localparam int PW   = $clog2(NPHYS);
  localparam logic [AW-1:0] A_CTRL  = AW'(NLOG);
  localparam logic [AW-1:0] A_STAT  = AW'(NLOG + 1);
  localparam logic [AW-1:0] A_NPHYS = AW'(NPHYS);
  localparam logic [AW-1:0] A_NLOG  = AW'(NLOG);

  logic [NPHYS:0]    ctrl_q;
  logic              enable;
  logic [NPHYS-1:0]  split;
  logic              commit;
  logic              is_cnt, is_hi_idx;
  logic [PW-1:0]     sel;
  logic [CW-1:0]     view   [NPHYS];
  logic [NPHYS-1:0]  ovf_hi, ovf_lo, pend;
  logic [NLOG-1:0]   status;
  logic [CW-1:0]     rd_mux, rdata_q;

  assign enable    = ctrl_q[0];
  assign split     = ctrl_q[NPHYS:1];
  assign commit    = wr_en_i && (addr_i == A_CTRL) && wdata_i[0];
  assign is_cnt    = addr_i < A_NLOG;
  assign is_hi_idx = addr_i < A_NPHYS;
  assign sel       = addr_i[PW-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i)                               ctrl_q <= '0;
    else if (wr_en_i && addr_i == A_CTRL)    ctrl_q <= wdata_i[NPHYS:0];
  end

  for (genvar p = 0; p < NPHYS; p++) begin : g_slice
    wr_kind_e kind;
    always_comb begin
      kind = WK_NONE;
      if (wr_en_i && is_cnt && sel == PW'(p)) begin
        if (split[p]) kind = is_hi_idx ? WK_HI : WK_LO;
        else          kind = is_hi_idx ? WK_FULL : WK_NONE;
      end
    end

    evb_slice #(.CW(CW)) u_slice (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .split_i   (split[p]),
      .cnt_en_i  (enable),
      .evt_hi_i  (evt_i[p]),
      .evt_lo_i  (evt_i[p+NPHYS]),
      .wr_kind_i (kind),
      .wr_data_i (wdata_i),
      .commit_i  (commit),
      .view_o    (view[p]),
      .ovf_hi_o  (ovf_hi[p]),
      .ovf_lo_o  (ovf_lo[p]),
      .pending_o (pend[p])
    );

    a_r2_unsplit_high_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && is_cnt && !is_hi_idx && sel == PW'(p) && !split[p] && !commit)
        |=> $stable(pend[p]));
  end

  evb_status #(.NL(NLOG)) u_status (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .set_i     ({ovf_lo, ovf_hi}),
    .rd_clr_i  (rd_en_i && addr_i == A_STAT),
    .mask_wr_i (wr_en_i && addr_i == A_STAT),
    .mask_i    (wdata_i[NLOG-1:0]),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (is_cnt) begin
      if (split[sel])
        rd_mux = is_hi_idx ? {{HW{1'b0}}, view[sel][CW-1:HW]}
                           : {{HW{1'b0}}, view[sel][HW-1:0]};
      else if (is_hi_idx)
        rd_mux = view[sel];
    end else if (addr_i == A_CTRL) begin
      rd_mux = {{(CW-NPHYS-1){1'b0}}, ctrl_q};
    end else if (addr_i == A_STAT) begin
      rd_mux = {{(CW-NLOG){1'b0}}, status};
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  a_r11_rdata_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_o));
  a_r1_ctrl_from_reset: assert property (@(posedge clk_i)
    rst_i |=> (ctrl_q == '0));
endmodule

// File: tb/evb_bank_test.sv
`timescale 1ns/1ps
module evb_bank_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] lv [8];
  logic [31:0] d;

  always #2 clk = ~clk;

  evb_bank uut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt = 8'b1 << k;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), d); chk("R1 register zero", d, 0);
    end

    // split all, disabled: latch writes (R2 R3 R4)
    wr(8, 32'h1E);
    for (int i = 0; i < 8; i++) begin
      lv[i] = 32'h1000 + 32'(i) * 32'h11;
      wr(4'(i), lv[i] | 32'hABCD_0000);
    end
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d); chk("R3 half write keeps other half / R4 latched read", d, lv[i]);
    end
    rd(8, d); chk("R11 control readback", d, 32'h1E);

    // enable commits (R5)
    wr(8, 32'h1F);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d); chk("R5 commit on enable", d, lv[i]);
    end

    // sweep: logical k gets k+1 events (R2 R6)
    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n <= k; n++) pulse(k);
      lv[k] = lv[k] + 32'(k + 1);
    end
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d); chk("R6 split counting and R2 mapping", d, lv[i]);
    end

    // write while enabled stays latched until control rewrite (R4 R5)
    wr(0, 32'hABCD);
    rd(0, d); chk("R4 latched read while enabled", d, 32'hABCD);
    pulse(0); pulse(4);
    rd(0, d); chk("R4 live count hidden by latch", d, 32'hABCD);
    rd(4, d); chk("R4 other half from latch", d, lv[4]);
    wr(8, 32'h1F);
    rd(0, d); chk("R5 commit while enabled", d, 32'hABCD);
    rd(4, d); chk("R5 committed lower half", d, lv[4]);

    // lower-half wrap, no carry, status and irq (R6 R7 R8 R9)
    wr(4, 32'hFFFF); wr(0, 32'h7); wr(8, 32'h1F);
    wr(9, 32'hFF);
    @(negedge clk);
    chk("R9 irq quiet with empty status", {31'b0, irq}, 0);
    pulse(4);
    @(negedge clk);
    chk("R9 irq on masked overflow", {31'b0, irq}, 1);
    rd(4, d); chk("R6 lower half wraps", d, 0);
    rd(0, d); chk("R6 no carry into upper", d, 32'h7);
    rd(9, d); chk("R7 lower wrap sets bit p+4", d, 32'h10);
    rd(9, d); chk("R8 read clears status", d, 0);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'b0, irq}, 0);

    // unsplit mode (R2 R6 R7 R9)
    wr(8, 32'h01);
    rd(0, d); chk("R2 unsplit full read", d, 32'h0007_0000);
    wr(1, 32'hFFFF_FFFE);
    wr(5, 32'h1234);
    wr(8, 32'h01);
    rd(5, d); chk("R2 high index reads zero unsplit", d, 0);
    rd(1, d); chk("R2 full write", d, 32'hFFFF_FFFE);
    pulse(5);
    rd(1, d); chk("R6 lower event ignored unsplit", d, 32'hFFFF_FFFE);
    pulse(1); pulse(1);
    rd(1, d); chk("R6 full counter wraps", d, 0);
    @(negedge clk);
    chk("R9 irq from full wrap", {31'b0, irq}, 1);
    wr(9, 32'h0);
    @(negedge clk);
    chk("R9 zero mask disables irq", {31'b0, irq}, 0);
    wr(9, 32'h02);
    @(negedge clk);
    chk("R9 mask re-enables irq", {31'b0, irq}, 1);
    rd(9, d); chk("R7 full wrap sets bit p", d, 32'h02);

    // commit and event in the same cycle (R10)
    wr(2, 32'd100);
    @(negedge clk); wr_en = 1; addr = 8; wdata = 32'h01; evt = 8'h04;
    @(negedge clk); wr_en = 0; evt = '0;
    rd(2, d); chk("R10 commit beats event", d, 32'd100);
    pulse(2);
    rd(2, d); chk("R6 counts after commit", d, 32'd101);

    // disabled: no counting (R6)
    wr(8, 32'h00);
    pulse(2);
    rd(2, d); chk("R6 no count when disabled", d, 32'd101);

    // overflow during status read (R8)
    wr(3, 32'hFFFF_FFFF);
    wr(8, 32'h01);
    rd(9, d);
    @(negedge clk); rd_en = 1; addr = 9; evt = 8'h08;
    @(negedge clk); rd_en = 0; evt = '0; d = rdata;
    chk("R8 read returns pre-overflow status", d, 0);
    rd(9, d); chk("R8 same-cycle overflow survives clear", d, 32'h08);
    rd(8, d); chk("R11 control readback", d, 32'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule